// File: doc/BRIEF.md
# Microoperation Decode and Datapath Executor

This block carries out one control word per clock on a small accumulator machine. The control word arrives as three 3-bit fields, and each field may name one register transfer. The transfers act on a 16-bit accumulator, a 16-bit data register, an 11-bit address register, an 11-bit program counter and an internal 2048-word by 16-bit memory. All the transfers named by one word take effect together at the next rising clock edge.

A sequencer outside this block supplies the fields every cycle and reads back the status outputs to make its branch decisions. The status outputs are the accumulator sign, an accumulator-zero flag, and the top five data-register bits. When an instruction sits in the data register, those five bits are the indirect flag (bit 15) and the 4-bit opcode (bits 14..11). The full register values are also brought out so that the rest of the machine can use them.

Top module: `uop_exec_top`

## Requirements
- R1: While `rst_n` is low, AC, DR, AR and PC are 0. The reset is asynchronous and is released on a clock edge.
- R2: The first field `fa_i` is decoded as follows: 0 no change; 1 AC gets AC+DR; 2 AC gets 0; 3 AC gets AC+1; 4 AC gets DR; 5 AR gets DR[10:0]; 6 AR gets PC; 7 memory[AR] gets DR. AR changes only under codes 5 and 6 of this field.
- R3: The second field `fb_i` is decoded as follows: 0 no change; 1 AC gets AC-DR; 2 AC gets AC OR DR; 3 AC gets AC AND DR; 4 DR gets memory[AR]; 5 DR gets AC; 6 DR gets DR+1; 7 DR[10:0] gets PC, with DR[15:11] kept.
- R4: The third field `fc_i` is decoded as follows: 0 no change; 1 AC gets AC XOR DR; 2 AC gets NOT AC; 3 AC shifts left; 4 AC shifts right; 5 PC gets PC+1; 6 PC gets AR; 7 no change.
- R5: Every transfer uses register and memory values from before the clock edge. For example, code 4 in `fa_i` together with code 5 in `fb_i` swaps AC and DR.
- R6: When two fields of one word write the same register, the third field wins over the second, and the second wins over the first.
- R7: Shifts fill the vacated bit with 0. AC and DR arithmetic wraps modulo 2^16, and PC+1 wraps from 2047 to 0.
- R8: Memory reads complete within the cycle. When one word both writes memory and loads DR from memory, DR receives the contents from before the write.
- R9: `ac_neg_o` equals AC[15]. `ac_zero_o` is 1 exactly when AC is 0. `dr_top_o` equals DR[15:11].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fa_i | input | 3 | First microoperation field |
| fb_i | input | 3 | Second microoperation field |
| fc_i | input | 3 | Third microoperation field |
| ac_o | output | 16 | Accumulator |
| dr_o | output | 16 | Data register |
| ar_o | output | 11 | Address register |
| pc_o | output | 11 | Program counter |
| ac_neg_o | output | 1 | Accumulator sign bit |
| ac_zero_o | output | 1 | Accumulator equals zero |
| dr_top_o | output | 5 | DR[15:11]: indirect flag and opcode |

## Verification
The hardest case to reach from the ports is a memory read whose expected value is known. The memory has no reset, and the only way to give it contents is to route a value through AC and DR and an address through PC and AR. The bench therefore opens with a three-word loop that writes a distinct value to all 2048 locations; this loop also drives PC through its wrap from 2047 to 0. Only after that does it issue random control words. Those random words include same-register conflicts and a simultaneous write and read of memory, and each of these is compared against the behavioural model.

// File: rtl/uop_pkg.sv
package uop_pkg;

  typedef enum logic [2:0] {
    FA_NOP, FA_ADD, FA_CLR, FA_INC, FA_LDDR, FA_ARDR, FA_ARPC, FA_WR
  } fa_op_e;

  typedef enum logic [2:0] {
    FB_NOP, FB_SUB, FB_OR, FB_AND, FB_RD, FB_DRAC, FB_DRINC, FB_DRPC
  } fb_op_e;

  typedef enum logic [2:0] {
    FC_NOP, FC_XOR, FC_NOT, FC_SHL, FC_SHR, FC_PCINC, FC_PCAR, FC_RSV
  } fc_op_e;

  typedef enum logic [3:0] {
    AC_KEEP, AC_SUM, AC_ZERO, AC_INC, AC_DR, AC_DIFF, AC_OR, AC_AND,
    AC_XOR, AC_INV, AC_SHL, AC_SHR
  } ac_src_e;

  typedef enum logic [2:0] {
    DR_KEEP, DR_MEM, DR_AC, DR_INC, DR_PC
  } dr_src_e;

  typedef enum logic [1:0] {
    AR_KEEP, AR_DR, AR_PC
  } ar_src_e;

  typedef enum logic [1:0] {
    PC_KEEP, PC_INC, PC_AR
  } pc_src_e;

  typedef struct packed {
    ac_src_e ac;
    dr_src_e dr;
    ar_src_e ar;
    pc_src_e pc;
    logic    mem_we;
  } uop_ctl_t;

endpackage

// File: rtl/uop_decode.sv
module uop_decode
  import uop_pkg::*;
(
  input  logic [2:0] fa_i,
  input  logic [2:0] fb_i,
  input  logic [2:0] fc_i,
  output uop_ctl_t   ctl_o
);

  fa_op_e fa;
  fb_op_e fb;
  fc_op_e fc;

  assign fa = fa_op_e'(fa_i);
  assign fb = fb_op_e'(fb_i);
  assign fc = fc_op_e'(fc_i);

  // Fields are applied in order, so a later field overrides an earlier one (R6).
  always_comb begin
    ctl_o.ac     = AC_KEEP;
    ctl_o.dr     = DR_KEEP;
    ctl_o.ar     = AR_KEEP;
    ctl_o.pc     = PC_KEEP;
    ctl_o.mem_we = 1'b0;

    case (fa)
      FA_ADD:  ctl_o.ac     = AC_SUM;
      FA_CLR:  ctl_o.ac     = AC_ZERO;
      FA_INC:  ctl_o.ac     = AC_INC;
      FA_LDDR: ctl_o.ac     = AC_DR;
      FA_ARDR: ctl_o.ar     = AR_DR;
      FA_ARPC: ctl_o.ar     = AR_PC;
      FA_WR:   ctl_o.mem_we = 1'b1;
      default: ;
    endcase

    case (fb)
      FB_SUB:   ctl_o.ac = AC_DIFF;
      FB_OR:    ctl_o.ac = AC_OR;
      FB_AND:   ctl_o.ac = AC_AND;
      FB_RD:    ctl_o.dr = DR_MEM;
      FB_DRAC:  ctl_o.dr = DR_AC;
      FB_DRINC: ctl_o.dr = DR_INC;
      FB_DRPC:  ctl_o.dr = DR_PC;
      default:  ;
    endcase

    case (fc)
      FC_XOR:   ctl_o.ac = AC_XOR;
      FC_NOT:   ctl_o.ac = AC_INV;
      FC_SHL:   ctl_o.ac = AC_SHL;
      FC_SHR:   ctl_o.ac = AC_SHR;
      FC_PCINC: ctl_o.pc = PC_INC;
      FC_PCAR:  ctl_o.pc = PC_AR;
      default:  ;  // FC_RSV behaves as no operation (R4)
    endcase
  end

endmodule

// File: rtl/uop_wordmem.sv
module uop_wordmem #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  // Read is combinational, so a same-word read returns the pre-write contents (R8).
  assign rdata_o = mem_q[addr_i];

  always_ff @(posedge clk) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  // R8: once a write has been made, reading the same address returns the written data.
  p_write_visible_r8: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> ((addr_i != $past(addr_i)) || (rdata_o == $past(wdata_i))));

endmodule

// File: rtl/uop_datapath.sv
module uop_datapath
  import uop_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  uop_ctl_t          ctl_i,
  output logic [DATA_W-1:0] ac_q,
  output logic [DATA_W-1:0] dr_q,
  output logic [ADDR_W-1:0] ar_q,
  output logic [ADDR_W-1:0] pc_q
);

  localparam int HI_W = DATA_W - ADDR_W;

  logic [DATA_W-1:0] ac_d, dr_d, mem_rdata;
  logic [ADDR_W-1:0] ar_d, pc_d;
  logic              ac_en, dr_en, ar_en, pc_en;

  uop_wordmem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) mem_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (ctl_i.mem_we),
    .addr_i  (ar_q),
    .wdata_i (dr_q),
    .rdata_o (mem_rdata)
  );

  assign ac_en = (ctl_i.ac != AC_KEEP);
  assign dr_en = (ctl_i.dr != DR_KEEP);
  assign ar_en = (ctl_i.ar != AR_KEEP);
  assign pc_en = (ctl_i.pc != PC_KEEP);

  // Next-state logic: every source is a pre-edge value (R5).
  always_comb begin
    case (ctl_i.ac)
      AC_SUM:  ac_d = ac_q + dr_q;
      AC_ZERO: ac_d = '0;
      AC_INC:  ac_d = ac_q + 1'b1;
      AC_DR:   ac_d = dr_q;
      AC_DIFF: ac_d = ac_q - dr_q;
      AC_OR:   ac_d = ac_q | dr_q;
      AC_AND:  ac_d = ac_q & dr_q;
      AC_XOR:  ac_d = ac_q ^ dr_q;
      AC_INV:  ac_d = ~ac_q;
      AC_SHL:  ac_d = {ac_q[DATA_W-2:0], 1'b0};
      AC_SHR:  ac_d = {1'b0, ac_q[DATA_W-1:1]};
      default: ac_d = ac_q;
    endcase

    case (ctl_i.dr)
      DR_MEM:  dr_d = mem_rdata;
      DR_AC:   dr_d = ac_q;
      DR_INC:  dr_d = dr_q + 1'b1;
      DR_PC:   dr_d = {dr_q[DATA_W-1 -: HI_W], pc_q};
      default: dr_d = dr_q;
    endcase

    case (ctl_i.ar)
      AR_DR:   ar_d = dr_q[ADDR_W-1:0];
      AR_PC:   ar_d = pc_q;
      default: ar_d = ar_q;
    endcase

    case (ctl_i.pc)
      PC_INC:  pc_d = pc_q + 1'b1;
      PC_AR:   pc_d = ar_q;
      default: pc_d = pc_q;
    endcase
  end

  // Register process with explicit clock enables (R1 reset).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_q <= '0;
      dr_q <= '0;
      ar_q <= '0;
      pc_q <= '0;
    end else begin
      if (ac_en) ac_q <= ac_d;
      if (dr_en) dr_q <= dr_d;
      if (ar_en) ar_q <= ar_d;
      if (pc_en) pc_q <= pc_d;
    end
  end

endmodule

// File: rtl/uop_exec_top.sv
module uop_exec_top
  import uop_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11,
  parameter int TOP_W  = DATA_W - ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        fa_i,
  input  logic [2:0]        fb_i,
  input  logic [2:0]        fc_i,
  output logic [DATA_W-1:0] ac_o,
  output logic [DATA_W-1:0] dr_o,
  output logic [ADDR_W-1:0] ar_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              ac_neg_o,
  output logic              ac_zero_o,
  output logic [TOP_W-1:0]  dr_top_o
);

  uop_ctl_t ctl;

  uop_decode dec_i (
    .fa_i  (fa_i),
    .fb_i  (fb_i),
    .fc_i  (fc_i),
    .ctl_o (ctl)
  );

  uop_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dp_i (
    .clk   (clk),
    .rst_n (rst_n),
    .ctl_i (ctl),
    .ac_q  (ac_o),
    .dr_q  (dr_o),
    .ar_q  (ar_o),
    .pc_q  (pc_o)
  );

  // Status for the sequencer (R9).
  assign ac_neg_o  = ac_o[DATA_W-1];
  assign ac_zero_o = (ac_o == '0);
  assign dr_top_o  = dr_o[DATA_W-1 -: TOP_W];

  // R4: PC increment field advances PC by one, wrapping.
  p_pc_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_i == FC_PCINC) |=> (pc_o == ADDR_W'($past(pc_o) + 1'b1)));

  // R2: AR holds unless the first field loads it.
  p_ar_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((fa_i != FA_ARDR) && (fa_i != FA_ARPC)) |=> $stable(ar_o));

  // R5: simultaneous AC<-DR and DR<-AC swap the two registers.
  p_swap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((fa_i == FA_LDDR) && (fb_i == FB_DRAC) && (fc_i == FC_NOP))
      |=> ((ac_o == $past(dr_o)) && (dr_o == $past(ac_o))));

  // R6: third field overrides the first when both target AC.
  p_fc_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((fa_i == FA_INC) && (fc_i == FC_NOT)) |=> (ac_o == ~$past(ac_o)));

  // R7: left shift fills bit 0 with zero.
  p_shl_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_i == FC_SHL) |=> (ac_o[0] == 1'b0));

endmodule

// File: tb/uop_exec_top_tb.sv
module uop_exec_top_tb_top;

  logic        clk;
  logic        rst_n;
  logic [2:0]  fa, fb, fc;
  logic [15:0] ac, dr;
  logic [10:0] ar, pc;
  logic        ac_neg, ac_zero;
  logic [4:0]  dr_top;

  int checks = 0;
  int errors = 0;
  int illegal = 0;

  // Reference state
  logic [15:0] m_ac, m_dr;
  logic [10:0] m_ar, m_pc;
  logic [15:0] m_mem [2048];

  uop_exec_top dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .fa_i      (fa),
    .fb_i      (fb),
    .fc_i      (fc),
    .ac_o      (ac),
    .dr_o      (dr),
    .ar_o      (ar),
    .pc_o      (pc),
    .ac_neg_o  (ac_neg),
    .ac_zero_o (ac_zero),
    .dr_top_o  (dr_top)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  // Behavioural model of one word: later fields overwrite earlier ones.
  task automatic model(input logic [2:0] a, input logic [2:0] b, input logic [2:0] c);
    logic [15:0] na, nd, rd;
    logic [10:0] nr, np;
    int tgt_ac, tgt_dr;
    na = m_ac; nd = m_dr; nr = m_ar; np = m_pc;
    rd = m_mem[m_ar];
    tgt_ac = 0; tgt_dr = 0;
    case (a)
      3'd1: begin na = m_ac + m_dr; tgt_ac++; end
      3'd2: begin na = 16'h0;       tgt_ac++; end
      3'd3: begin na = m_ac + 16'd1; tgt_ac++; end
      3'd4: begin na = m_dr;        tgt_ac++; end
      3'd5: nr = m_dr[10:0];
      3'd6: nr = m_pc;
      default: ;
    endcase
    case (b)
      3'd1: begin na = m_ac - m_dr; tgt_ac++; end
      3'd2: begin na = m_ac | m_dr; tgt_ac++; end
      3'd3: begin na = m_ac & m_dr; tgt_ac++; end
      3'd4: begin nd = rd;          tgt_dr++; end
      3'd5: begin nd = m_ac;        tgt_dr++; end
      3'd6: begin nd = m_dr + 16'd1; tgt_dr++; end
      3'd7: begin nd = {m_dr[15:11], m_pc}; tgt_dr++; end
      default: ;
    endcase
    case (c)
      3'd1: begin na = m_ac ^ m_dr;        tgt_ac++; end
      3'd2: begin na = ~m_ac;              tgt_ac++; end
      3'd3: begin na = m_ac << 1;          tgt_ac++; end
      3'd4: begin na = m_ac >> 1;          tgt_ac++; end
      3'd5: np = m_pc + 11'd1;
      3'd6: np = m_ar;
      default: ;
    endcase
    if (tgt_ac > 1 || tgt_dr > 1) illegal++;
    if (a == 3'd7) m_mem[m_ar] = m_dr;
    m_ac = na; m_dr = nd; m_ar = nr; m_pc = np;
  endtask

  // Drive one word at the falling edge, let it take effect, compare at the next falling edge.
  task automatic step(input logic [2:0] a, input logic [2:0] b, input logic [2:0] c);
    fa = a; fb = b; fc = c;
    model(a, b, c);
    @(posedge clk);
    @(negedge clk);
    chk("R2 R3 R4 R5 R6 R7 R8 ac", ac, m_ac);
    chk("R3 R5 R8 dr", dr, m_dr);
    chk("R2 ar", {5'd0, ar}, {5'd0, m_ar});
    chk("R4 R7 pc", {5'd0, pc}, {5'd0, m_pc});
    chk("R9 sign", {15'd0, ac_neg}, {15'd0, m_ac[15]});
    chk("R9 zero", {15'd0, ac_zero}, {15'd0, (m_ac == 16'h0)});
    chk("R9 top", {11'd0, dr_top}, {11'd0, m_dr[15:11]});
  endtask

  initial begin
    rst_n = 1'b0;
    fa = 3'd0; fb = 3'd0; fc = 3'd0;
    m_ac = '0; m_dr = '0; m_ar = '0; m_pc = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 ac", ac, 16'h0);
    chk("R1 dr", dr, 16'h0);
    chk("R1 ar", {5'd0, ar}, 16'h0);
    chk("R1 pc", {5'd0, pc}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // Fill memory: location k gets k+1 (R8 setup, R7 PC wrap)
    for (int k = 0; k < 2048; k++) begin
      step(3'd3, 3'd0, 3'd0);
      step(3'd6, 3'd5, 3'd5);
      step(3'd7, 3'd0, 3'd0);
    end
    chk("R7 pc wrap", {5'd0, pc}, 16'h0);
    chk("R2 ac count", ac, 16'h0800);

    // Directed corner cases
    step(3'd2, 3'd0, 3'd0);
    chk("R9 zero after clear", {15'd0, ac_zero}, 16'd1);
    step(3'd0, 3'd0, 3'd2);
    chk("R4 complement", ac, 16'hFFFF);
    chk("R9 sign", {15'd0, ac_neg}, 16'd1);
    step(3'd3, 3'd0, 3'd0);
    chk("R7 ac wrap", ac, 16'h0000);
    step(3'd0, 3'd0, 3'd2);
    step(3'd0, 3'd0, 3'd3);
    chk("R7 shl fill", ac, 16'hFFFE);
    step(3'd0, 3'd0, 3'd4);
    chk("R7 shr fill", ac, 16'h7FFF);
    step(3'd4, 3'd5, 3'd0);
    chk("R5 swap ac", ac, 16'h0800);
    chk("R5 swap dr", dr, 16'h7FFF);
    step(3'd3, 3'd2, 3'd2);
    chk("R6 last field wins", ac, 16'hF7FF);
    step(3'd7, 3'd4, 3'd0);
    chk("R8 read before write", dr, 16'h0800);
    step(3'd0, 3'd4, 3'd0);
    chk("R8 written value", dr, 16'h7FFF);
    step(3'd0, 3'd7, 3'd0);
    chk("R3 dr low from pc", dr, 16'h7800);
    chk("R9 dr top", {11'd0, dr_top}, 16'h000F);
    step(3'd0, 3'd0, 3'd7);
    chk("R4 reserved no-op", ac, 16'hF7FF);

    // Random control words
    for (int n = 0; n < 20000; n++) begin
      step(3'($urandom % 8), 3'($urandom % 8), 3'($urandom % 8));
    end
    $display("illegal microcode words seen (same register twice): %0d", illegal);
    summary();
  end

endmodule